// File: doc/BRIEF.md
# Precise Exception Tracking Pipeline

This block follows up to five in-flight instructions through fetch, decode, execute, memory and writeback slots and makes their faults precise. The instruction in each of the first four slots may be given a fault report as a 3-bit cause code. The block does not act on a report when it arrives. It folds the report into a small status field that travels with that instruction. Only when the instruction reaches writeback does the block decide whether the instruction commits or traps. Faults are therefore taken in program order, even when a younger instruction reports first.

When the writeback instruction carries a cause, its register write and memory write strobes are withheld and the trap is raised in that same cycle. Every younger instruction, and the fetch presented in the trap cycle, becomes a bubble that keeps moving down the pipe. Fetch is redirected to a fixed trap vector, so the handler can be presented in the following cycle. The block records the restart address, the cause, a delay-slot flag and a saved status word, and it switches to kernel mode. For an instruction that sits in a branch delay slot, the restart address points back at the branch.

Top module: `precise_exc_pipe`

## Requirements
- R1: After reset, no slot holds an instruction. `commit_o`, `trap_o`, `kmode_o`, `epc_o`, `cause_o`, `bd_o` and `sstat_o` are all zero.
- R2: A fetched instruction with no accepted fault shows up at writeback five clock edges after it is presented. There `commit_o` is 1, `commit_pc_o` is its address, and `commit_rwe_o`/`commit_mwe_o` carry the write flags it was fetched with.
- R3: Cause codes are: 1 fetch page fault, 2 fetch misaligned, 3 fetch protection, 4 illegal opcode, 5 arithmetic, 6 data page fault, 7 data access violation (misaligned or protection). A report is accepted only in its own slot: 1–3 on `rpt_if_i`, 4 on `rpt_id_i`, 5 on `rpt_ex_i`, 6–7 on `rpt_mem_i`. Any other nonzero code on a slot is ignored, and the instruction then commits normally.
- R4: Once an instruction carries a cause, later reports against it do not change it. The first accepted cause is the one trapped on.
- R5: When a faulting instruction reaches writeback, `trap_o` is 1 in that cycle. `commit_o`, `commit_rwe_o` and `commit_mwe_o` are 0, and `redirect_pc_o` equals `TRAP_VEC`.
- R6: On a trap, all younger instructions in the pipe, and the fetch presented in the trap cycle, are squashed. None of them ever commits or traps. An instruction presented in the next cycle proceeds normally.
- R7: When an older instruction's memory-slot fault and a younger instruction's fetch-slot fault arrive in the same cycle, the trap is taken with the older instruction's cause and address.
- R8: One edge after a trap, `cause_o` holds the cause. Outside a delay slot, `epc_o` holds the faulting address and `bd_o` is 0. For an instruction fetched with `fetch_dslot_i`=1, `epc_o` holds the address minus `INSN_BYTES` and `bd_o` is 1.
- R9: One edge after a trap, `kmode_o` is 1 and `sstat_o` = {mode before the trap (bit 4), delay-slot flag (bit 3), cause (bits 2:0)}.
- R10: Fault reports given while a slot holds no instruction have no effect, and no trap follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld_i | input | 1 | An instruction is presented to the fetch slot |
| fetch_pc_i | input | PC_W | Address of the presented instruction |
| fetch_dslot_i | input | 1 | Presented instruction sits in a branch delay slot |
| fetch_rwe_i | input | 1 | Instruction will write a register |
| fetch_mwe_i | input | 1 | Instruction will write memory |
| rpt_if_i | input | 3 | Fault report against the fetch-slot instruction |
| rpt_id_i | input | 3 | Fault report against the decode-slot instruction |
| rpt_ex_i | input | 3 | Fault report against the execute-slot instruction |
| rpt_mem_i | input | 3 | Fault report against the memory-slot instruction |
| commit_o | output | 1 | Writeback instruction commits this cycle |
| commit_pc_o | output | PC_W | Address of the writeback instruction |
| commit_rwe_o | output | 1 | Register write enable at writeback |
| commit_mwe_o | output | 1 | Memory write strobe at writeback |
| trap_o | output | 1 | Trap taken this cycle |
| redirect_pc_o | output | PC_W | Fetch redirect target, valid with trap_o |
| epc_o | output | PC_W | Saved restart address |
| cause_o | output | 3 | Saved cause code |
| bd_o | output | 1 | Saved delay-slot flag |
| kmode_o | output | 1 | Kernel mode |
| sstat_o | output | 5 | Saved status word |

## Verification
The bench builds the block with a 32-bit address, a four-byte instruction size and a trap vector at 0x180. The vector lies well clear of the addresses used as stimulus, so a redirected fetch cannot be mistaken for an ordinary one. The four-byte step makes the delay-slot correction to the restart address a visible, nonzero difference. These values also let a single run trap twice or more, so the saved status word is seen in both user and kernel mode. They allow a memory-slot fault and a fetch-slot fault to be lined up in the same cycle three instructions apart.

// File: rtl/pet_pkg.sv
package pet_pkg;

  localparam int CAUSE_W = 3;
  localparam int NSTG    = 5;

  typedef logic [CAUSE_W-1:0] cause_t;

  localparam cause_t C_NONE  = 3'd0;
  localparam cause_t C_IPF   = 3'd1;
  localparam cause_t C_IMIS  = 3'd2;
  localparam cause_t C_IPROT = 3'd3;
  localparam cause_t C_ILLOP = 3'd4;
  localparam cause_t C_ARITH = 3'd5;
  localparam cause_t C_DPF   = 3'd6;
  localparam cause_t C_DACC  = 3'd7;

  typedef struct packed {
    logic   vld;
    logic   dslot;
    logic   rwe;
    logic   mwe;
    cause_t cause;
  } ctl_t;

  // Which slot may raise which cause (0 fetch, 1 decode, 2 execute, 3 memory)
  function automatic logic cause_legal(input int stg, input cause_t c);
    case (stg)
      0:       return (c == C_IPF) || (c == C_IMIS) || (c == C_IPROT);
      1:       return (c == C_ILLOP);
      2:       return (c == C_ARITH);
      3:       return (c == C_DPF) || (c == C_DACC);
      default: return 1'b0;
    endcase
  endfunction

  // True when some slot strictly upstream of stg could have raised c
  function automatic logic cause_from_upstream(input int stg, input cause_t c);
    for (int s = 0; s < stg; s++) begin
      if (cause_legal(s, c)) return 1'b1;
    end
    return 1'b0;
  endfunction

endpackage

// File: rtl/pet_stage.sv
module pet_stage
  import pet_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int STG  = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kill_i,
  input  ctl_t            ctl_i,
  input  logic [PC_W-1:0] pc_i,
  input  cause_t          rpt_i,
  output ctl_t            ctl_o,
  output logic [PC_W-1:0] pc_o,
  output ctl_t            fwd_o
);

  ctl_t            ctl_q;
  logic [PC_W-1:0] pc_q;
  logic            accept_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      pc_q  <= '0;
    end else begin
      ctl_q <= kill_i ? '0 : ctl_i;
      pc_q  <= pc_i;
    end
  end

  // A report lands only on a live, still-clean instruction and only if legal here
  assign accept_w = ctl_q.vld && (ctl_q.cause == C_NONE) && cause_legal(STG, rpt_i);

  always_comb begin
    fwd_o = ctl_q;
    if (accept_w) fwd_o.cause = rpt_i;
  end

  assign ctl_o = ctl_q;
  assign pc_o  = pc_q;

  // R6: a bubble carries no write intent and no cause
  p_bubble_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.vld |-> (ctl_q.cause == C_NONE) && !ctl_q.rwe && !ctl_q.mwe);

  // R3: a held cause must have come from a slot upstream of this one
  p_cause_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.cause != C_NONE) |-> cause_from_upstream(STG, ctl_q.cause));

endmodule

// File: rtl/pet_trap.sv
module pet_trap
  import pet_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  cause_t          cause_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            dslot_i,
  output logic [PC_W-1:0] epc_o,
  output cause_t          cause_o,
  output logic            bd_o,
  output logic            kmode_o,
  output logic [4:0]      sstat_o
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  // Restart address: a delay-slot instruction restarts at its branch
  function automatic logic [PC_W-1:0] restart_addr(input logic [PC_W-1:0] pc,
                                                   input logic dslot);
    return dslot ? (pc - STEP) : pc;
  endfunction

  logic [PC_W-1:0] epc_q;
  cause_t          cause_q;
  logic            bd_q;
  logic            kmode_q;
  logic [4:0]      sstat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= C_NONE;
      bd_q    <= 1'b0;
      kmode_q <= 1'b0;
      sstat_q <= '0;
    end else if (take_i) begin
      epc_q   <= restart_addr(pc_i, dslot_i);
      cause_q <= cause_i;
      bd_q    <= dslot_i;
      sstat_q <= {kmode_q, dslot_i, cause_i};
      kmode_q <= 1'b1;
    end
  end

  assign epc_o   = epc_q;
  assign cause_o = cause_q;
  assign bd_o    = bd_q;
  assign kmode_o = kmode_q;
  assign sstat_o = sstat_q;

  // R9: trapping always lands in kernel mode
  p_kernel_after_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> kmode_o);

  // R8: outside a delay slot the faulting address itself is kept
  p_epc_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !dslot_i) |=> (epc_o == $past(pc_i)) && !bd_o);

  // R8: inside a delay slot the kept address differs from the slot's own
  p_epc_dslot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && dslot_i) |=> bd_o && (epc_o != $past(pc_i)));

  // R8: saved state only moves on a trap
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(epc_o) && $stable(cause_o) && $stable(sstat_o));

endmodule

// File: rtl/precise_exc_pipe.sv
module precise_exc_pipe
  import pet_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [PC_W-1:0] TRAP_VEC   = 'h180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_vld_i,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            fetch_dslot_i,
  input  logic            fetch_rwe_i,
  input  logic            fetch_mwe_i,
  input  logic [2:0]      rpt_if_i,
  input  logic [2:0]      rpt_id_i,
  input  logic [2:0]      rpt_ex_i,
  input  logic [2:0]      rpt_mem_i,
  output logic            commit_o,
  output logic [PC_W-1:0] commit_pc_o,
  output logic            commit_rwe_o,
  output logic            commit_mwe_o,
  output logic            trap_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic [PC_W-1:0] epc_o,
  output logic [2:0]      cause_o,
  output logic            bd_o,
  output logic            kmode_o,
  output logic [4:0]      sstat_o
);

  localparam int LAST = NSTG - 1;

  ctl_t            in_ctl [NSTG];
  logic [PC_W-1:0] in_pc  [NSTG];
  ctl_t            q_ctl  [NSTG];
  logic [PC_W-1:0] q_pc   [NSTG];
  ctl_t            fw_ctl [NSTG];
  cause_t          rpt    [NSTG];
  logic [NSTG-1:0] live_w;
  ctl_t            fetch_ctl;
  logic            trap_w;
  logic            commit_w;

  assign rpt[0] = rpt_if_i;
  assign rpt[1] = rpt_id_i;
  assign rpt[2] = rpt_ex_i;
  assign rpt[3] = rpt_mem_i;
  assign rpt[4] = C_NONE;

  always_comb begin
    fetch_ctl       = '0;
    fetch_ctl.vld   = fetch_vld_i;
    fetch_ctl.dslot = fetch_vld_i && fetch_dslot_i;
    fetch_ctl.rwe   = fetch_vld_i && fetch_rwe_i;
    fetch_ctl.mwe   = fetch_vld_i && fetch_mwe_i;
  end

  for (genvar k = 0; k < NSTG; k++) begin : g_slot
    if (k == 0) begin : g_head
      assign in_ctl[k] = fetch_ctl;
      assign in_pc[k]  = fetch_pc_i;
    end else begin : g_body
      assign in_ctl[k] = fw_ctl[k-1];
      assign in_pc[k]  = q_pc[k-1];
    end

    pet_stage #(.PC_W(PC_W), .STG(k)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .kill_i(trap_w),
      .ctl_i (in_ctl[k]),
      .pc_i  (in_pc[k]),
      .rpt_i (rpt[k]),
      .ctl_o (q_ctl[k]),
      .pc_o  (q_pc[k]),
      .fwd_o (fw_ctl[k])
    );

    assign live_w[k] = q_ctl[k].vld;

    if (k > 0) begin : g_keep
      // R4: a cause already carried survives the move to the next slot
      p_keep_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_ctl[k-1].cause != C_NONE) && !trap_w) |=> (q_ctl[k].cause == $past(q_ctl[k-1].cause)));
    end
  end

  // Decision point: the writeback slot alone decides commit versus trap
  assign trap_w   = q_ctl[LAST].vld && (q_ctl[LAST].cause != C_NONE);
  assign commit_w = q_ctl[LAST].vld && (q_ctl[LAST].cause == C_NONE);

  assign commit_o      = commit_w;
  assign commit_pc_o   = q_pc[LAST];
  assign commit_rwe_o  = commit_w && q_ctl[LAST].rwe;
  assign commit_mwe_o  = commit_w && q_ctl[LAST].mwe;
  assign trap_o        = trap_w;
  assign redirect_pc_o = trap_w ? TRAP_VEC : '0;

  pet_trap #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_trap (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (trap_w),
    .cause_i(q_ctl[LAST].cause),
    .pc_i   (q_pc[LAST]),
    .dslot_i(q_ctl[LAST].dslot),
    .epc_o  (epc_o),
    .cause_o(cause_o),
    .bd_o   (bd_o),
    .kmode_o(kmode_o),
    .sstat_o(sstat_o)
  );

  // R5: a trap cycle never lets any write through
  p_trap_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !commit_o && !commit_rwe_o && !commit_mwe_o);

  // R6: after a trap every slot is empty
  p_squash_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_w |=> ($countones(live_w) == 0));

  // R5: redirect target is the trap vector whenever a trap is raised
  p_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (redirect_pc_o == TRAP_VEC));

endmodule

// File: tb/precise_exc_pipe_test.sv
`timescale 1ns/1ps
module precise_exc_pipe_test;

  localparam logic [31:0] VEC = 32'h0000_0180;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_vld_i, fetch_dslot_i, fetch_rwe_i, fetch_mwe_i;
  logic [31:0] fetch_pc_i;
  logic [2:0]  rpt_if_i, rpt_id_i, rpt_ex_i, rpt_mem_i;
  logic        commit_o, commit_rwe_o, commit_mwe_o, trap_o, bd_o, kmode_o;
  logic [31:0] commit_pc_o, redirect_pc_o, epc_o;
  logic [2:0]  cause_o;
  logic [4:0]  sstat_o;

  int n_chk = 0;
  int n_err = 0;
  logic kmode_m = 1'b0;

  always #10 clk = ~clk;

  precise_exc_pipe #(.PC_W(32), .INSN_BYTES(4), .TRAP_VEC(VEC)) uut (
    .clk(clk), .rst_n(rst_n),
    .fetch_vld_i(fetch_vld_i), .fetch_pc_i(fetch_pc_i), .fetch_dslot_i(fetch_dslot_i),
    .fetch_rwe_i(fetch_rwe_i), .fetch_mwe_i(fetch_mwe_i),
    .rpt_if_i(rpt_if_i), .rpt_id_i(rpt_id_i), .rpt_ex_i(rpt_ex_i), .rpt_mem_i(rpt_mem_i),
    .commit_o(commit_o), .commit_pc_o(commit_pc_o), .commit_rwe_o(commit_rwe_o),
    .commit_mwe_o(commit_mwe_o), .trap_o(trap_o), .redirect_pc_o(redirect_pc_o),
    .epc_o(epc_o), .cause_o(cause_o), .bd_o(bd_o), .kmode_o(kmode_o), .sstat_o(sstat_o)
  );

  // Vector: {dslot, rwe, mwe, stage(3, 7 = none), code(3), expected cause(3)}
  localparam int NV = 12;
  localparam logic [11:0] TBL [NV] = '{
    {1'b0, 1'b1, 1'b0, 3'd7, 3'd0, 3'd0},  // R2 clean, register write
    {1'b0, 1'b0, 1'b1, 3'd7, 3'd0, 3'd0},  // R2 clean, memory write
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd1, 3'd1},  // R3 fetch page fault
    {1'b0, 1'b0, 1'b1, 3'd0, 3'd3, 3'd3},  // R3 fetch protection
    {1'b0, 1'b1, 1'b0, 3'd1, 3'd4, 3'd4},  // R3 illegal opcode
    {1'b0, 1'b1, 1'b1, 3'd2, 3'd5, 3'd5},  // R3 arithmetic
    {1'b1, 1'b0, 1'b1, 3'd3, 3'd7, 3'd7},  // R8 data violation in delay slot
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd5, 3'd0},  // R3 wrong slot, ignored
    {1'b0, 1'b0, 1'b1, 3'd3, 3'd4, 3'd0},  // R3 wrong slot, ignored
    {1'b1, 1'b1, 1'b0, 3'd1, 3'd2, 3'd0},  // R3 wrong slot in delay slot, ignored
    {1'b1, 1'b1, 1'b0, 3'd0, 3'd2, 3'd2},  // R8 fetch misaligned in delay slot
    {1'b0, 1'b1, 1'b0, 3'd3, 3'd6, 3'd6}   // R3 data page fault
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    fetch_vld_i = 0; fetch_pc_i = '0; fetch_dslot_i = 0; fetch_rwe_i = 0; fetch_mwe_i = 0;
    rpt_if_i = 0; rpt_id_i = 0; rpt_ex_i = 0; rpt_mem_i = 0;
  endtask

  task automatic present(input logic [31:0] pc, input logic ds, input logic rw, input logic mw);
    fetch_vld_i = 1; fetch_pc_i = pc; fetch_dslot_i = ds; fetch_rwe_i = rw; fetch_mwe_i = mw;
  endtask

  task automatic set_rpt(input int stg, input logic [2:0] code);
    case (stg)
      0: rpt_if_i = code;
      1: rpt_id_i = code;
      2: rpt_ex_i = code;
      3: rpt_mem_i = code;
      default: ;
    endcase
  endtask

  // Check saved state one edge after a trap, against the bench's own mode model
  task automatic chk_saved(input string req, input logic [31:0] pc, input logic ds,
                           input logic [2:0] c);
    logic [31:0] exp_epc = ds ? pc - 32'd4 : pc;
    chk(req, "epc", epc_o, exp_epc);
    chk(req, "cause", {29'd0, cause_o}, {29'd0, c});
    chk(req, "bd", {31'd0, bd_o}, {31'd0, ds});
    chk("R9", "status word", {27'd0, sstat_o}, {27'd0, kmode_m, ds, c});
    kmode_m = 1'b1;
    chk("R9", "kernel mode", {31'd0, kmode_o}, 32'd1);
  endtask

  task automatic run_entry(input int idx);
    logic [11:0] e = TBL[idx];
    logic        ds = e[11], rw = e[10], mw = e[9];
    int          stg = int'(e[8:6]);
    logic [2:0]  code = e[5:3], expc = e[2:0];
    logic [31:0] pc = 32'h1000 + 32'(idx) * 32'h10;
    present(pc, ds, rw, mw);
    for (int c = 0; c < 4; c++) begin
      step();
      clear_in();
      if (stg == c) set_rpt(c, code);
    end
    step();
    clear_in();
    if (expc == 3'd0) begin
      chk("R2", "commit", {31'd0, commit_o}, 32'd1);
      chk("R2", "commit pc", commit_pc_o, pc);
      chk("R2", "rwe", {31'd0, commit_rwe_o}, {31'd0, rw});
      chk("R2", "mwe", {31'd0, commit_mwe_o}, {31'd0, mw});
      chk("R3", "no trap", {31'd0, trap_o}, 32'd0);
      step();
    end else begin
      chk("R5", "trap", {31'd0, trap_o}, 32'd1);
      chk("R5", "commit blocked", {29'd0, commit_o, commit_rwe_o, commit_mwe_o}, 32'd0);
      chk("R5", "redirect", redirect_pc_o, VEC);
      step();
      chk_saved("R8", pc, ds, expc);
    end
  endtask

  initial begin
    #(20ns * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog all-requirements: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", "commit", {31'd0, commit_o}, 32'd0);
    chk("R1", "trap", {31'd0, trap_o}, 32'd0);
    chk("R1", "kmode", {31'd0, kmode_o}, 32'd0);
    chk("R1", "epc", epc_o, 32'd0);
    chk("R1", "saved", {23'd0, sstat_o, cause_o, bd_o}, 32'd0);

    for (int i = 0; i < NV; i++) run_entry(i);

    // R4: fetch misaligned first, arithmetic later; first cause wins
    present(32'h3000, 0, 1, 0);
    step(); clear_in(); rpt_if_i = 3'd2;
    step(); clear_in();
    step(); clear_in(); rpt_ex_i = 3'd5;
    step(); clear_in();
    step();
    chk("R4", "trap", {31'd0, trap_o}, 32'd1);
    step();
    chk_saved("R4", 32'h3000, 0, 3'd2);

    // R7 and R6: older memory fault against younger fetch fault in the same cycle
    present(32'h2000, 0, 1, 0); step();
    present(32'h2004, 0, 1, 1); step();
    present(32'h2008, 0, 1, 0); step();
    present(32'h200c, 0, 1, 0); step();
    present(32'h2010, 0, 1, 1); rpt_mem_i = 3'd6; rpt_if_i = 3'd1; step();
    clear_in();
    chk("R7", "trap", {31'd0, trap_o}, 32'd1);
    chk("R7", "commit blocked", {31'd0, commit_o}, 32'd0);
    present(32'h2014, 0, 1, 1);
    step();
    clear_in();
    chk_saved("R7", 32'h2000, 0, 3'd6);
    chk("R6", "bubble 1", {30'd0, commit_o, trap_o}, 32'd0);
    present(VEC, 0, 1, 0);
    step();
    clear_in();
    for (int b = 2; b <= 5; b++) begin
      chk("R6", $sformatf("bubble %0d", b), {30'd0, commit_o, trap_o}, 32'd0);
      step();
    end
    chk("R6", "handler commit", {31'd0, commit_o}, 32'd1);
    chk("R6", "handler pc", commit_pc_o, VEC);
    step();

    // R10: reports against empty slots
    rpt_if_i = 3'd1; rpt_id_i = 3'd4; rpt_ex_i = 3'd5; rpt_mem_i = 3'd6;
    step();
    clear_in();
    for (int t = 0; t < 6; t++) begin
      chk("R10", "no trap", {30'd0, commit_o, trap_o}, 32'd0);
      step();
    end
    chk("R10", "cause unchanged", {29'd0, cause_o}, 32'd6);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule